// File: doc/BRIEF.md
# Signed Array Multiplier with Magnitude Complementers

This block multiplies two two's-complement operands, each one sign bit plus `MAG_BITS` value bits, in a single combinational path. Each operand passes through a conditional complementer that is switched on by its own sign bit, so an unsigned core only ever sees non-negative magnitudes. The core is a plain grid of AND gates forming the partial products and rows of ripple full adders summing them into a `2*MAG_BITS`-bit magnitude product. A third conditional complementer, switched on when the operand signs disagree, turns that magnitude back into a signed result.

Each complementer works by scanning upward from bit 0: every bit up to and including the lowest 1 passes through unchanged, and every bit above it is inverted. No multiply operator is used anywhere; the whole datapath is gates. The result is presented as a `2*MAG_BITS`-bit product field plus a separate sign bit. Taken together, `{prod_sign, product}` is the `2*MAG_BITS+1`-bit two's-complement product. Each operand is sorted by a small decoder into one of four classes. OC_ZERO means sign 0 with a zero value field. OC_POS means sign 0 with a nonzero value field. OC_LIMIT means sign 1 with a zero value field, which is the most negative value. OC_NEG means sign 1 with a nonzero value field. The OC_LIMIT class has a magnitude that does not fit the core and raises the range flag. The block holds no state, so there are no states or transitions; the four operand classes take that role.

Top module: `signed_array_mult`

## Requirements
- R1: With both operands non-negative, `product` equals the unsigned product of the two value fields. Each partial-product bit is the AND of one multiplicand bit and one multiplier bit, summed by full adders.
- R2: An operand whose sign bit (bit `MAG_BITS`) is 1 is replaced by its two's-complement negation before reaching the core, so negative operands contribute their magnitude.
- R3: Complementing keeps every bit up to and including the lowest set bit and inverts all higher bits. At the ports, the lowest set bit of a nonzero `product` sits at the same position as in the magnitude product.
- R4: When the operand sign bits differ and the magnitude product `m` is nonzero, `product` equals `2^(2*MAG_BITS) - m`. When the sign bits agree, `product` equals `m`.
- R5: For a nonzero product with `range_err` low, `prod_sign` is the XOR of the two operand sign bits.
- R6: A zero product is reported as `product` = 0 with `prod_sign` = 0, whatever the operand signs are.
- R7: `range_err` is 1 exactly when either operand is the most negative value (sign 1, value field all zeros). In that case `product` and `prod_sign` are undefined.
- R8: With `range_err` low, `{prod_sign, product}` read as a `2*MAG_BITS+1`-bit two's-complement number equals the signed product of the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | MAG_BITS+1 | Multiplicand, two's complement, sign in the top bit |
| op_b | input | MAG_BITS+1 | Multiplier, two's complement, sign in the top bit |
| product | output | 2*MAG_BITS | Product field: the magnitude, or its complement when the signs differ |
| prod_sign | output | 1 | Sign of the product, 0 for a zero product |
| range_err | output | 1 | High when either operand is the most negative value |

## Verification
The bench sweeps every pair of operands for a five-bit configuration. That covers zero multiplied by a negative value, which a design without zero suppression would report as a negative zero with the sign bit set. It also covers the largest magnitudes, where a short carry chain in the top array row would drop the high product bit. Operands with even values and mixed signs check that the low bits of the product stay unchanged up to the first 1; an off-by-one scan in the complementer would corrupt exactly that bit. Both most-negative operands are compared against the range flag, and a decoder that confused them with zero would miss the flag.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int DEF_MAG_BITS = 4;

    typedef enum logic [1:0] {
        OC_ZERO  = 2'b00,
        OC_POS   = 2'b01,
        OC_NEG   = 2'b10,
        OC_LIMIT = 2'b11
    } operand_class_e;

endpackage

// File: rtl/smul_sign_decode.sv
module smul_sign_decode #(
    parameter int MAG_BITS = smul_pkg::DEF_MAG_BITS
) (
    input  logic [MAG_BITS:0]        opnd,
    output smul_pkg::operand_class_e cls
);
    import smul_pkg::*;

    logic value_zero;

    assign value_zero = (opnd[MAG_BITS-1:0] == '0);

    always_comb begin
        unique case ({opnd[MAG_BITS], value_zero})
            2'b01:   cls = OC_ZERO;
            2'b00:   cls = OC_POS;
            2'b10:   cls = OC_NEG;
            2'b11:   cls = OC_LIMIT;
            default: cls = OC_ZERO;
        endcase
    end

endmodule

// File: rtl/smul_complementer.sv
module smul_complementer #(
    parameter int WIDTH = smul_pkg::DEF_MAG_BITS + 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);
    // found_one[i] is set once a 1 has appeared in some bit below i
    logic [WIDTH-1:0] found_one;

    assign found_one[0] = 1'b0;

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_scan
            assign found_one[i] = found_one[i-1] | din[i-1];
        end
        for (i = 0; i < WIDTH; i++) begin : g_flip
            assign dout[i] = din[i] ^ (en & found_one[i]);
        end
    endgenerate

    always_comb begin
        if (en) begin
            AST_CPL_NEGATES: assert (WIDTH'(dout + din) == '0); // R2
        end
        if (!en) begin
            AST_CPL_PASSES: assert (dout == din); // R4
        end
    end

endmodule

// File: rtl/smul_full_adder.sv
module smul_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    assign s    = x ^ y ^ cin;
    assign cout = (x & y) | (x & cin) | (y & cin);
endmodule

// File: rtl/smul_array_core.sv
module smul_array_core #(
    parameter int MAG_BITS = smul_pkg::DEF_MAG_BITS
) (
    input  logic [MAG_BITS-1:0]   mx,
    input  logic [MAG_BITS-1:0]   my,
    output logic [2*MAG_BITS-1:0] mp
);
    localparam int N = MAG_BITS;

    // pp[r][k] = mx[k] & my[r]
    logic [N-1:0] pp    [N];
    // running upper part after row r: N bits of sum plus the carry out
    logic [N:0]   hi    [N];
    logic [N:0]   carry [N];

    genvar r, k;
    generate
        for (r = 0; r < N; r++) begin : g_row
            for (k = 0; k < N; k++) begin : g_and
                assign pp[r][k] = mx[k] & my[r];
            end
            if (r == 0) begin : g_first
                assign hi[0]    = {1'b0, pp[0]};
                assign carry[0] = '0;
            end else begin : g_add
                assign carry[r][0] = 1'b0;
                for (k = 0; k < N; k++) begin : g_fa
                    smul_full_adder u_fa (
                        .x    (pp[r][k]),
                        .y    (hi[r-1][k+1]),
                        .cin  (carry[r][k]),
                        .s    (hi[r][k]),
                        .cout (carry[r][k+1])
                    );
                end
                assign hi[r][N] = carry[r][N];
            end
            assign mp[r] = hi[r][0];
        end
    endgenerate

    assign mp[2*N-1:N] = hi[N-1][N:1];

    always_comb begin
        if (mx == '0 || my == '0) begin
            AST_CORE_ZERO: assert (mp == '0); // R1
        end
        AST_CORE_LSB: assert (mp[0] == (mx[0] & my[0])); // R1
    end

endmodule

// File: rtl/signed_array_mult.sv
module signed_array_mult #(
    parameter int MAG_BITS = smul_pkg::DEF_MAG_BITS
) (
    input  logic [MAG_BITS:0]     op_a,
    input  logic [MAG_BITS:0]     op_b,
    output logic [2*MAG_BITS-1:0] product,
    output logic                  prod_sign,
    output logic                  range_err
);
    import smul_pkg::*;

    localparam int OPW = MAG_BITS + 1;
    localparam int PW  = 2 * MAG_BITS;

    operand_class_e   cls_a, cls_b;
    logic [OPW-1:0]   abs_a, abs_b;
    logic [PW-1:0]    mag_prod;
    logic             signs_differ;
    logic             mag_zero;

    smul_sign_decode #(.MAG_BITS(MAG_BITS)) u_cls_a (.opnd(op_a), .cls(cls_a));
    smul_sign_decode #(.MAG_BITS(MAG_BITS)) u_cls_b (.opnd(op_b), .cls(cls_b));

    smul_complementer #(.WIDTH(OPW)) u_cpl_a (
        .din (op_a), .en (op_a[MAG_BITS]), .dout (abs_a)
    );
    smul_complementer #(.WIDTH(OPW)) u_cpl_b (
        .din (op_b), .en (op_b[MAG_BITS]), .dout (abs_b)
    );

    smul_array_core #(.MAG_BITS(MAG_BITS)) u_core (
        .mx (abs_a[MAG_BITS-1:0]),
        .my (abs_b[MAG_BITS-1:0]),
        .mp (mag_prod)
    );

    assign signs_differ = op_a[MAG_BITS] ^ op_b[MAG_BITS];
    assign mag_zero     = (mag_prod == '0);

    smul_complementer #(.WIDTH(PW)) u_cpl_out (
        .din (mag_prod), .en (signs_differ), .dout (product)
    );

    assign prod_sign = signs_differ & ~mag_zero;
    assign range_err = (cls_a == OC_LIMIT) || (cls_b == OC_LIMIT);

    always_comb begin
        if (!range_err) begin
            AST_MAG_POSITIVE: assert (!abs_a[MAG_BITS] && !abs_b[MAG_BITS]); // R2
        end
        if (product == '0) begin
            AST_ZERO_SIGN: assert (!prod_sign); // R6
        end
        if (!range_err && product != '0) begin
            AST_SIGN_XOR: assert (prod_sign == (op_a[MAG_BITS] ^ op_b[MAG_BITS])); // R5
        end
        if (op_a[MAG_BITS] && op_a[MAG_BITS-1:0] == '0) begin
            AST_RANGE_FLAG: assert (range_err); // R7
        end
    end

endmodule

// File: tb/signed_array_mult_test.sv
module signed_array_mult_test;

    localparam int CLK_PERIOD = 10;
    localparam int MB  = 4;
    localparam int OPW = MB + 1;
    localparam int PW  = 2 * MB;

    logic            clk = 1'b0;
    logic [MB:0]     op_a = '0;
    logic [MB:0]     op_b = '0;
    logic [PW-1:0]   product;
    logic            prod_sign;
    logic            range_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    signed_array_mult #(.MAG_BITS(MB)) uut (
        .op_a      (op_a),
        .op_b      (op_b),
        .product   (product),
        .prod_sign (prod_sign),
        .range_err (range_err)
    );

    task automatic check(input string req, input int actual, input int expected,
                         input int av, input int bv);
        n_tests++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d",
                     req, av, bv, actual, expected);
        end
    endtask

    function automatic int to_signed(input logic [MB:0] v);
        return v[MB] ? int'(v) - (1 << OPW) : int'(v);
    endfunction

    function automatic int low_one(input int v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        // reset-like initial state: zero operands
        check("R6 product at zero", int'(product), 0, 0, 0);
        check("R6 sign at zero", int'(prod_sign), 0, 0, 0);
        check("R7 flag at zero", int'(range_err), 0, 0, 0);

        for (int i = 0; i < (1 << OPW); i++) begin
            for (int j = 0; j < (1 << OPW); j++) begin
                int  sa, sb, sp, mag, exp_prod, full, act_full;
                bit  exp_range, exp_sign;
                op_a = OPW'(i);
                op_b = OPW'(j);
                @(negedge clk);
                sa = to_signed(op_a);
                sb = to_signed(op_b);
                exp_range = (sa == -(1 << MB)) || (sb == -(1 << MB));
                check("R7 range flag", int'(range_err), int'(exp_range), sa, sb);
                if (!exp_range) begin
                    sp  = sa * sb;
                    mag = (sp < 0) ? -sp : sp;
                    exp_sign = (sp < 0);
                    exp_prod = exp_sign ? ((1 << PW) - mag) : mag;
                    if (sa >= 0 && sb >= 0)
                        check("R1 unsigned product", int'(product), mag, sa, sb);
                    else if (exp_sign)
                        check("R4 complemented product", int'(product), exp_prod, sa, sb);
                    else
                        check("R2 magnitudes of negatives", int'(product), exp_prod, sa, sb);
                    if (mag == 0) begin
                        check("R6 zero product", int'(product), 0, sa, sb);
                        check("R6 zero sign", int'(prod_sign), 0, sa, sb);
                    end else begin
                        check("R5 sign", int'(prod_sign), int'(exp_sign), sa, sb);
                        check("R3 lowest set bit", low_one(int'(product)), low_one(mag), sa, sb);
                    end
                    full = sp & ((1 << (PW + 1)) - 1);
                    act_full = int'({prod_sign, product});
                    check("R8 signed result", act_full, full, sa, sb);
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule